// File: doc/BRIEF.md
# Byte-Granular Funnel Aligner

This block takes two 256-bit vector operands and a byte count. It places the high operand above the low operand to form one 512-bit word. It shifts that word toward its least significant end by the given number of whole bytes and returns the bottom 256 bits. Bytes shifted in from above are zero. The usual use is to pull a byte-misaligned window out of two adjacent vector words. If the same vector is given as both operands, the block acts as a circular byte rotator.

The operands and the count enter through one valid/ready input stream. The result leaves through a valid/ready output stream after one register stage.

Input-side rules:
- A transfer happens on a rising clock edge where both `in_valid` and `in_ready` are high.
- `in_ready` is high whenever the output register is empty, or when its current result is being taken in the same cycle.
- The upstream side must hold its data stable while `in_valid` is high and `in_ready` is low.

Output-side rules:
- When `out_ready` is low, the result is held, unchanged, until it is taken.
- The stage can accept a new input and hand over the previous result in the same cycle, so it keeps full throughput.

Top module: `byte_funnel_align`

## Requirements
- R1: With `in_hi` as the upper 256 bits and `in_lo` as the lower 256 bits of a 512-bit word, `out_data` byte i (bits 8i+7..8i) equals byte i+`in_shift` of that word when i+`in_shift` < 64, and is 0x00 otherwise.
- R2: A shift of 0 returns `in_lo` unchanged.
- R3: A shift of 32 returns `in_hi` unchanged.
- R4: Every shift from 64 to 255 returns all zeros.
- R5: When `in_hi` equals `in_lo` equals X and the shift n is in 0..32, byte i of the result equals byte (i+n) mod 32 of X, which is a circular right rotation.
- R6: Take X as four 64-bit elements e0 (bits 63..0) up to e3 (bits 255..192), give X as both operands, and shift by 8. The result is {e0, e3, e2, e1}: each element moves down one place and e0 wraps to the top.
- R7: An input accepted at a rising edge makes `out_valid` high, with its result on `out_data`, right after that edge. `out_valid` never rises without an accepted input at the previous edge.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_data` stays stable and `in_ready` is low. While `out_valid` is low, `in_ready` is high.
- R9: While `rst_n` is low (asynchronous, active low), `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operands and count are valid |
| in_ready | output | 1 | Block can accept an input this cycle |
| in_hi | input | 256 | Operand placed in the upper half of the joined word |
| in_lo | input | 256 | Operand placed in the lower half of the joined word |
| in_shift | input | 8 | Right shift distance in bytes |
| out_valid | output | 1 | Result on `out_data` is valid |
| out_ready | input | 1 | Downstream side takes the result |
| out_data | output | 256 | Aligned result |

## Verification
Each result is due one rising edge after its input is accepted. It then stays on the output for as long as `out_ready` is held low.

Stimulus and sampling are kept apart in time:
- Inputs are driven just after each rising edge.
- All sampling happens on falling edges.
- An expected value is queued only once the falling-edge sample shows `in_ready` high, so the accepting edge is known exactly.
- The monitor pops and compares only on falling edges where both output handshake signals are high.

Directed steps add two checks at fixed times. The first checks `out_valid` at the first falling edge after acceptance. The second checks that the output holds for several cycles while the output side is stalled.

// File: rtl/bfa_pkg.sv
package bfa_pkg;
  typedef logic [7:0] byte_t;
  localparam int unsigned DEF_VEC_BYTES = 32;
  localparam int unsigned DEF_CNT_W     = 8;
endpackage

// File: rtl/bfa_select_core.sv
module bfa_select_core
  import bfa_pkg::*;
#(
  parameter int unsigned VEC_BYTES = DEF_VEC_BYTES,
  parameter int unsigned CNT_W     = DEF_CNT_W
) (
  input  logic [VEC_BYTES*8-1:0] hi_i,
  input  logic [VEC_BYTES*8-1:0] lo_i,
  input  logic [CNT_W-1:0]       shift_i,
  output logic [VEC_BYTES*8-1:0] res_o
);
  localparam int unsigned JB    = 2 * VEC_BYTES;
  localparam int unsigned IW    = CNT_W + 1;
  localparam int unsigned SEL_W = $clog2(JB);

  byte_t joined [JB];

  // R1: low operand fills bytes 0..VEC_BYTES-1, high operand the rest
  for (genvar j = 0; j < VEC_BYTES; j++) begin : g_join
    assign joined[j]             = lo_i[j*8 +: 8];
    assign joined[j + VEC_BYTES] = hi_i[j*8 +: 8];
  end

  // one source selector per result byte; sources past the top read zero (R4)
  for (genvar i = 0; i < VEC_BYTES; i++) begin : g_pick
    logic [IW-1:0] src;
    assign src = IW'(i) + IW'(shift_i);
    assign res_o[i*8 +: 8] = (src < IW'(JB)) ? joined[src[SEL_W-1:0]] : 8'h00;
  end
endmodule

// File: rtl/bfa_out_stage.sv
module bfa_out_stage #(
  parameter int unsigned W = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  // stage may load when empty or when its content leaves this cycle (R8)
  assign up_ready = !full_q || dn_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (up_ready) begin
      full_q <= up_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (up_valid && up_ready) begin
      data_q <= up_data;
    end
  end

  assign dn_valid = full_q;
  assign dn_data  = data_q;
endmodule

// File: rtl/byte_funnel_align.sv
module byte_funnel_align
  import bfa_pkg::*;
#(
  parameter int unsigned VEC_BYTES = DEF_VEC_BYTES,
  parameter int unsigned CNT_W     = DEF_CNT_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [VEC_BYTES*8-1:0] in_hi,
  input  logic [VEC_BYTES*8-1:0] in_lo,
  input  logic [CNT_W-1:0]       in_shift,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [VEC_BYTES*8-1:0] out_data
);
  localparam int unsigned VW = VEC_BYTES * 8;

  logic [VW-1:0] aligned;

  bfa_select_core #(
    .VEC_BYTES(VEC_BYTES),
    .CNT_W    (CNT_W)
  ) u_core (
    .hi_i   (in_hi),
    .lo_i   (in_lo),
    .shift_i(in_shift),
    .res_o  (aligned)
  );

  bfa_out_stage #(
    .W(VW)
  ) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_valid(in_valid),
    .up_ready(in_ready),
    .up_data (aligned),
    .dn_valid(out_valid),
    .dn_ready(out_ready),
    .dn_data (out_data)
  );
endmodule

// File: rtl/byte_funnel_align_chk.sv
module byte_funnel_align_chk #(
  parameter int unsigned VEC_BYTES = 32,
  parameter int unsigned CNT_W     = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [VEC_BYTES*8-1:0] in_hi,
  input logic [VEC_BYTES*8-1:0] in_lo,
  input logic [CNT_W-1:0]       in_shift,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [VEC_BYTES*8-1:0] out_data
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(VEC_BYTES);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(2 * VEC_BYTES);

  logic take;
  assign take = in_valid && in_ready;

  assert_reset_idle_R9: assert property (@(posedge clk) !rst_n |=> !out_valid);

  assert_ready_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(take));

  assert_zero_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_shift == '0) |=> (out_data == $past(in_lo)));

  assert_half_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_shift == HALF) |=> (out_data == $past(in_hi)));

  assert_past_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_shift >= FULL) |=> (out_data == '0));
endmodule

bind byte_funnel_align byte_funnel_align_chk #(
  .VEC_BYTES(VEC_BYTES),
  .CNT_W    (CNT_W)
) u_chk (.*);

// File: tb/sim_byte_funnel_align.sv
`timescale 1ns/1ps
module sim_byte_funnel_align;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] in_hi = '0;
  logic [255:0] in_lo = '0;
  logic [7:0]   in_shift = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [255:0] out_data;

  int total = 0;
  int bad = 0;
  bit rand_ready = 1'b0;
  logic [255:0] exp_q[$];
  string        tag_q[$];

  always #2.5 clk = ~clk;

  byte_funnel_align u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hi(in_hi), .in_lo(in_lo), .in_shift(in_shift),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  // behavioural model of the joined-word shift
  function automatic logic [255:0] model(logic [255:0] a, logic [255:0] b, int n);
    logic [511:0] w;
    if (n >= 64) return '0;
    w = {a, b} >> (n * 8);
    return w[255:0];
  endfunction

  function automatic string pick_tag(logic [255:0] a, logic [255:0] b, int n);
    if (n == 0) return "R2";
    if (n == 32) return "R3";
    if (n >= 64) return "R4";
    if (a == b) return "R5";
    return "R1";
  endfunction

  task automatic check(bit ok, string req, logic [255:0] act, logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: called just after a rising edge, returns just after the accepting edge
  task automatic send(logic [255:0] a, logic [255:0] b, int n,
                      logic [255:0] exp, string tag);
    in_hi = a; in_lo = b; in_shift = 8'(n); in_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  // output readiness generator
  initial forever begin
    @(posedge clk); #1;
    if (rand_ready) out_ready = ($urandom % 4) != 0;
  end

  // monitor / scoreboard
  initial forever begin
    @(negedge clk);
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", out_data, '0);
      end else begin
        logic [255:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_data === e, t, out_data, e);
      end
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [255:0] x, y, d0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9", {255'd0, out_valid}, '0);
    check(in_ready == 1'b1, "R9", {255'd0, in_ready}, 256'd1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R7: result due right after the accepting edge
    x = rnd256(); y = rnd256();
    send(x, y, 5, model(x, y, 5), "R1");
    @(negedge clk);
    check(out_valid == 1'b1, "R7", {255'd0, out_valid}, 256'd1);
    drain();

    // R8: stalled output holds and blocks input
    out_ready = 1'b0;
    x = rnd256(); y = rnd256();
    send(x, y, 17, model(x, y, 17), "R8");
    @(negedge clk);
    d0 = out_data;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R8", {255'd0, out_valid}, 256'd1);
      check(in_ready == 1'b0, "R8", {255'd0, in_ready}, '0);
      check(out_data === d0, "R8", out_data, d0);
    end
    @(posedge clk); #1;
    out_ready = 1'b1;
    drain();

    // R1..R4: full sweep of counts 0..70, random stall pattern
    rand_ready = 1'b1;
    for (int pass = 0; pass < 2; pass++) begin
      for (int n = 0; n <= 70; n++) begin
        x = rnd256(); y = rnd256();
        send(x, y, n, model(x, y, n), pick_tag(x, y, n));
      end
    end

    // R5: same operand gives rotation
    for (int n = 0; n <= 32; n++) begin
      logic [255:0] r;
      x = rnd256();
      for (int i = 0; i < 32; i++) r[i*8 +: 8] = x[((i + n) % 32)*8 +: 8];
      send(x, x, n, r, "R5");
    end

    // R6: 64-bit elements move down one place, lowest wraps to top
    x = rnd256();
    send(x, x, 8, {x[63:0], x[255:192], x[191:128], x[127:64]}, "R6");

    // R4: every count past the joined word
    for (int n = 64; n <= 255; n++) begin
      x = rnd256(); y = rnd256();
      send(x, y, n, '0, "R4");
    end

    drain();
    rand_ready = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7", {255'd0, out_valid}, '0);
    summary();
  end
endmodule